// File: doc/BRIEF.md
# TLB Array Maintenance Port

This block holds the contents of a small instruction TLB (4 entries) and a larger unified TLB (64 entries). It gives a system bus direct read and write access to the address and data arrays of both. One access port carries a 2-bit array select, an address and a write word. The entry index and the sub-mode are decoded from fixed address bits.

Besides direct access, the block offers three maintenance actions:
- An associative write searches every entry of both TLBs for a page that matches. It then rewrites only the valid and dirty bits of each matching entry, and it reports when more than one entry in a TLB matched.
- A load strobe copies three page-table-entry words into the unified entry chosen by a replace index.
- A control write with the invalidate bit set clears every valid flag at once.

Address translation itself belongs to the surrounding logic. This block only keeps the arrays consistent.

Top module: `tlb_maint_port`

## Requirements
- R1: After reset every entry of both TLBs reads as all zeros, and `multi_hit` is 0.
- R2: `acc_sel` picks the target array: 0 is the instruction address array, 1 the instruction data array, 2 the unified address array and 3 the unified data array. The unified entry index is `acc_addr[13:8]` and the instruction entry index is `acc_addr[8:7]`. Read data appears on `acc_rdata` one clock after the read is accepted and holds until the next read. Array state changes only on an access, a load or an invalidate.
- R3: A unified address-array write with `acc_addr[7]`=0 updates several fields of the indexed entry. The page number comes from bits 31:10, the ID from bits 7:0, valid from bit 8 and dirty from bit 9. A read returns the page number in 31:10, dirty in 9, valid in 8 and the ID in 7:0.
- R4: An instruction address-array write stores the page number (31:10), the ID (7:0) and valid (bit 8). Its read has bit 9 at 0. An instruction data-array write keeps only the flag bits selected by mask 0x1DA. The data-array read returns the physical page in 28:10 and the flags in 8:0.
- R5: A unified data-array write with `acc_addr[23]`=0 stores the physical page from bits 28:10 and the flags from bits 8:0, and a read returns them in the same positions. With `acc_addr[23]`=1 the write keeps only bits 3:0 as an auxiliary field, the read returns that field zero-extended, and the page and flags are left alone.
- R6: A unified address-array write with `acc_addr[7]`=1 is associative. It takes its ID from `pte_hi[7:0]`. An entry matches when its share flag (flag bit 1) is set or its ID is equal, and when its page number equals the write's bits 31:10 outside that entry's ignored low bits. The valid bit plays no part in matching. Every matching unified entry takes valid from bit 8 and dirty from bit 9, and every matching instruction entry takes valid from bit 8. No other field and no other entry changes.
- R7: The flag bits {7,4} set the page size, and therefore how many low page-number bits a match ignores. The codes are 00 for 1K (none), 01 for 4K (2 bits), 10 for 64K (6 bits) and 11 for 1M (10 bits). A flags write takes effect on the next match.
- R8: `multi_hit` is 1 for exactly the cycle after an associative write that matched more than one entry in either TLB. At all other times it is 0.
- R9: A cycle with `ld_tlb`=1 fills the unified entry at `ld_idx`. The page number comes from `pte_hi[31:10]` and the ID from `pte_hi[7:0]`. The physical page comes from `pte_lo[28:10]` and the flags from `pte_lo[8:0]`. The auxiliary field comes from `pte_aux[3:0]`.
- R10: A cycle with `ctrl_we`=1 and `ctrl_wdata[2]`=1 clears the valid flag of every entry in both TLBs and keeps all other fields. This clear wins over a write or load in the same cycle. A control write with bit 2 at 0 has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_valid | input | 1 | Array access strobe |
| acc_write | input | 1 | 1 for write, 0 for read |
| acc_sel | input | 2 | Array select (see R2) |
| acc_addr | input | 32 | Access address (index and mode bits) |
| acc_wdata | input | 32 | Write word |
| acc_rdata | output | 32 | Registered read word |
| pte_hi | input | 32 | Page-table-entry high word (page number, ID) |
| pte_lo | input | 32 | Page-table-entry low word (physical page, flags) |
| pte_aux | input | 32 | Page-table-entry auxiliary word |
| ld_tlb | input | 1 | Load strobe |
| ld_idx | input | 6 | Unified entry to load (log2 of unified depth) |
| ctrl_we | input | 1 | Control write strobe |
| ctrl_wdata | input | 32 | Control word; bit 2 requests invalidate |
| multi_hit | output | 1 | Multiple associative matches seen |

## Verification
The hardest case to reach is an associative write that has to tell matches and non-matches apart. The bench prepares a neighbourhood of entries that almost match:
- entries of different page sizes that share a page number;
- an entry with equal page bits but a foreign ID;
- an entry that matches only through its share flag;
- invalid entries that must still match.

It then issues associative writes whose low page bits sit inside or just outside each size's ignored field. Reading every prepared entry back through the array ports shows which ones took the new valid and dirty bits. A final write that hits two unified entries and one instruction entry exposes the multi-hit flag.

// File: rtl/tlb_maint_port.sv
module tlb_maint_port #(
  parameter int UTLB_N = 64,
  parameter int ITLB_N = 4,
  parameter int INV_BIT = 2
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      acc_valid,
  input  logic                      acc_write,
  input  logic [1:0]                acc_sel,
  input  logic [31:0]               acc_addr,
  input  logic [31:0]               acc_wdata,
  output logic [31:0]               acc_rdata,
  input  logic [31:0]               pte_hi,
  input  logic [31:0]               pte_lo,
  input  logic [31:0]               pte_aux,
  input  logic                      ld_tlb,
  input  logic [$clog2(UTLB_N)-1:0] ld_idx,
  input  logic                      ctrl_we,
  input  logic [31:0]               ctrl_wdata,
  output logic                      multi_hit
);

  localparam int UIW = $clog2(UTLB_N);
  localparam int IIW = $clog2(ITLB_N);
  localparam int U_LSB = 8;
  localparam int I_LSB = 7;
  localparam logic [8:0] I_FLAG_KEEP = 9'h1DA;

  function automatic logic [21:0] page_keep(input logic [8:0] f);
    case ({f[7], f[4]})
      2'b00:   return 22'h3FFFFF;
      2'b01:   return 22'h3FFFFC;
      2'b10:   return 22'h3FFFC0;
      default: return 22'h3FFC00;
    endcase
  endfunction

  logic [21:0] u_vpn  [UTLB_N];
  logic [7:0]  u_asid [UTLB_N];
  logic [18:0] u_ppn  [UTLB_N];
  logic [8:0]  u_flg  [UTLB_N];
  logic [3:0]  u_aux  [UTLB_N];
  logic [21:0] i_vpn  [ITLB_N];
  logic [7:0]  i_asid [ITLB_N];
  logic [18:0] i_ppn  [ITLB_N];
  logic [8:0]  i_flg  [ITLB_N];

  logic [UTLB_N-1:0] u_hit, u_vld;
  logic [ITLB_N-1:0] i_hit, i_vld;

  wire wr = acc_valid & acc_write;
  wire rd = acc_valid & ~acc_write;
  wire [UIW-1:0] uidx = acc_addr[U_LSB +: UIW];
  wire [IIW-1:0] iidx = acc_addr[I_LSB +: IIW];
  wire assoc = acc_addr[7];
  wire data2 = acc_addr[23];
  wire [21:0] w_vpn = acc_wdata[31:10];
  wire [7:0]  s_asid = pte_hi[7:0];

  wire do_iaddr = wr & (acc_sel == 2'd0);
  wire do_idata = wr & (acc_sel == 2'd1);
  wire do_uaddr = wr & (acc_sel == 2'd2) & ~assoc;
  wire do_assoc = wr & (acc_sel == 2'd2) & assoc;
  wire do_udata = wr & (acc_sel == 2'd3) & ~data2;
  wire do_uaux  = wr & (acc_sel == 2'd3) & data2;
  wire inval    = ctrl_we & ctrl_wdata[INV_BIT];

  logic unused_bits;
  assign unused_bits = ^{acc_addr, pte_lo, pte_hi, pte_aux, ctrl_wdata};

  for (genvar g = 0; g < UTLB_N; g++) begin : g_utlb
    assign u_hit[g] = (u_flg[g][1] || u_asid[g] == s_asid) &&
                      (((u_vpn[g] ^ w_vpn) & page_keep(u_flg[g])) == 22'd0);
    assign u_vld[g] = u_flg[g][8];
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        u_vpn[g]  <= '0;
        u_asid[g] <= '0;
        u_ppn[g]  <= '0;
        u_flg[g]  <= '0;
        u_aux[g]  <= '0;
      end else begin
        if (do_uaddr && uidx == UIW'(g)) begin
          u_vpn[g]    <= w_vpn;
          u_asid[g]   <= acc_wdata[7:0];
          u_flg[g][8] <= acc_wdata[8];
          u_flg[g][2] <= acc_wdata[9];
        end
        if (do_assoc && u_hit[g]) begin
          u_flg[g][8] <= acc_wdata[8];
          u_flg[g][2] <= acc_wdata[9];
        end
        if (do_udata && uidx == UIW'(g)) begin
          u_ppn[g] <= acc_wdata[28:10];
          u_flg[g] <= acc_wdata[8:0];
        end
        if (do_uaux && uidx == UIW'(g))
          u_aux[g] <= acc_wdata[3:0];
        if (ld_tlb && ld_idx == UIW'(g)) begin
          u_vpn[g]  <= pte_hi[31:10];
          u_asid[g] <= pte_hi[7:0];
          u_ppn[g]  <= pte_lo[28:10];
          u_flg[g]  <= pte_lo[8:0];
          u_aux[g]  <= pte_aux[3:0];
        end
        if (inval)
          u_flg[g][8] <= 1'b0;
      end
    end
  end

  for (genvar g = 0; g < ITLB_N; g++) begin : g_itlb
    assign i_hit[g] = (i_flg[g][1] || i_asid[g] == s_asid) &&
                      (((i_vpn[g] ^ w_vpn) & page_keep(i_flg[g])) == 22'd0);
    assign i_vld[g] = i_flg[g][8];
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        i_vpn[g]  <= '0;
        i_asid[g] <= '0;
        i_ppn[g]  <= '0;
        i_flg[g]  <= '0;
      end else begin
        if (do_iaddr && iidx == IIW'(g)) begin
          i_vpn[g]    <= w_vpn;
          i_asid[g]   <= acc_wdata[7:0];
          i_flg[g][8] <= acc_wdata[8];
        end
        if (do_assoc && i_hit[g])
          i_flg[g][8] <= acc_wdata[8];
        if (do_idata && iidx == IIW'(g)) begin
          i_ppn[g] <= acc_wdata[28:10];
          i_flg[g] <= acc_wdata[8:0] & I_FLAG_KEEP;
        end
        if (inval)
          i_flg[g][8] <= 1'b0;
      end
    end
  end

  logic [31:0] rd_word;
  always_comb begin
    case (acc_sel)
      2'd0:    rd_word = {i_vpn[iidx], 1'b0, i_flg[iidx][8], i_asid[iidx]};
      2'd1:    rd_word = {3'b000, i_ppn[iidx], 1'b0, i_flg[iidx]};
      2'd2:    rd_word = {u_vpn[uidx], u_flg[uidx][2], u_flg[uidx][8], u_asid[uidx]};
      default: rd_word = data2 ? {28'd0, u_aux[uidx]}
                               : {3'b000, u_ppn[uidx], 1'b0, u_flg[uidx]};
    endcase
  end

  wire u_multi = |(u_hit & (u_hit - UTLB_N'(1)));
  wire i_multi = |(i_hit & (i_hit - ITLB_N'(1)));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc_rdata <= '0;
      multi_hit <= 1'b0;
    end else begin
      if (rd)
        acc_rdata <= rd_word;
      multi_hit <= do_assoc & (u_multi | i_multi);
    end
  end

endmodule

// File: rtl/tlb_maint_port_chk.sv
module tlb_maint_port_chk #(
  parameter int UTLB_N = 64,
  parameter int ITLB_N = 4
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic                      acc_valid,
  input logic                      acc_write,
  input logic [1:0]                acc_sel,
  input logic [31:0]               acc_addr,
  input logic [31:0]               acc_rdata,
  input logic [31:0]               pte_lo,
  input logic                      ld_tlb,
  input logic [$clog2(UTLB_N)-1:0] ld_idx,
  input logic                      ctrl_we,
  input logic [31:0]               ctrl_wdata,
  input logic                      multi_hit,
  input logic [UTLB_N-1:0]         u_vld,
  input logic [ITLB_N-1:0]         i_vld
);

  wire clr = ctrl_we & ctrl_wdata[2];

  AST_MH_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
    multi_hit |-> $past(acc_valid && acc_write && acc_sel == 2'd2 && acc_addr[7])); // R8

  AST_INVAL_ALL: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (u_vld == '0 && i_vld == '0)); // R10

  AST_QUIET_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    (!acc_valid && !ld_tlb && !clr) |=> ($stable(u_vld) && $stable(i_vld))); // R2

  AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !(acc_valid && !acc_write) |=> $stable(acc_rdata)); // R2

  AST_LOAD_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_tlb && pte_lo[8] && !clr) |=> u_vld[$past(ld_idx)]); // R9

endmodule

bind tlb_maint_port tlb_maint_port_chk #(.UTLB_N(UTLB_N), .ITLB_N(ITLB_N)) u_chk (
  .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_write(acc_write),
  .acc_sel(acc_sel), .acc_addr(acc_addr), .acc_rdata(acc_rdata), .pte_lo(pte_lo),
  .ld_tlb(ld_tlb), .ld_idx(ld_idx), .ctrl_we(ctrl_we), .ctrl_wdata(ctrl_wdata),
  .multi_hit(multi_hit), .u_vld(u_vld), .i_vld(i_vld)
);

// File: tb/tlb_maint_port_tb.sv
module tlb_maint_port_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        acc_valid = 1'b0, acc_write = 1'b0;
  logic [1:0]  acc_sel = '0;
  logic [31:0] acc_addr = '0, acc_wdata = '0, acc_rdata;
  logic [31:0] pte_hi = '0, pte_lo = '0, pte_aux = '0;
  logic        ld_tlb = 1'b0;
  logic [5:0]  ld_idx = '0;
  logic        ctrl_we = 1'b0;
  logic [31:0] ctrl_wdata = '0;
  logic        multi_hit;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  tlb_maint_port u_dut (
    .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_write(acc_write),
    .acc_sel(acc_sel), .acc_addr(acc_addr), .acc_wdata(acc_wdata), .acc_rdata(acc_rdata),
    .pte_hi(pte_hi), .pte_lo(pte_lo), .pte_aux(pte_aux), .ld_tlb(ld_tlb), .ld_idx(ld_idx),
    .ctrl_we(ctrl_we), .ctrl_wdata(ctrl_wdata), .multi_hit(multi_hit)
  );

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [1:0] sel, input logic [31:0] addr, input logic [31:0] data);
    @(negedge clk);
    acc_valid = 1'b1; acc_write = 1'b1; acc_sel = sel; acc_addr = addr; acc_wdata = data;
    @(negedge clk);
    acc_valid = 1'b0; acc_write = 1'b0;
  endtask

  task automatic rd(input logic [1:0] sel, input logic [31:0] addr, output logic [31:0] d);
    @(negedge clk);
    acc_valid = 1'b1; acc_write = 1'b0; acc_sel = sel; acc_addr = addr;
    @(negedge clk);
    acc_valid = 1'b0;
    d = acc_rdata;
  endtask

  task automatic expect_rd(input string tag, input logic [1:0] sel, input logic [31:0] addr,
                           input logic [31:0] exp);
    logic [31:0] d;
    rd(sel, addr, d);
    chk(tag, d, exp);
  endtask

  task automatic t_reset;
    expect_rd("R1 utlb addr 0", 2'd2, 32'h0, 32'h0);
    expect_rd("R1 itlb data 3", 2'd1, 32'h180, 32'h0);
    chk("R1 multi_hit", {31'd0, multi_hit}, 32'h0);
  endtask

  task automatic t_utlb_addr;
    wr(2'd2, 32'h0500, 32'h048D17A5);
    expect_rd("R3 utlb addr 5", 2'd2, 32'h0500, 32'h048D17A5);
    expect_rd("R2 neighbour 6", 2'd2, 32'h0600, 32'h0);
    wr(2'd2, 32'h3F00, 32'h7000_0033);
    expect_rd("R2 index 63", 2'd2, 32'h3F00, 32'h7000_0033);
  endtask

  task automatic t_utlb_data;
    wr(2'd3, 32'h0500, 32'hFFFFFFFF);
    expect_rd("R5 utlb data 5", 2'd3, 32'h0500, 32'h1FFFFDFF);
    wr(2'd3, 32'h0080_0500, 32'hFFFFFFFF);
    expect_rd("R5 aux field", 2'd3, 32'h0080_0500, 32'h0000000F);
    expect_rd("R5 aux keeps data", 2'd3, 32'h0500, 32'h1FFFFDFF);
  endtask

  task automatic t_itlb;
    wr(2'd0, 32'h0100, 32'hFFFFFFFF);
    expect_rd("R4 itlb addr 2", 2'd0, 32'h0100, 32'hFFFFFDFF);
    wr(2'd1, 32'h0100, 32'hFFFFFFFF);
    expect_rd("R4 itlb data mask", 2'd1, 32'h0100, 32'h1FFFFDDA);
  endtask

  task automatic t_load;
    pte_hi = 32'h12345678; pte_lo = 32'hE0001D06; pte_aux = 32'hFFFFFFF3; ld_idx = 6'd17;
    @(negedge clk); ld_tlb = 1'b1;
    @(negedge clk); ld_tlb = 1'b0;
    expect_rd("R9 load addr", 2'd2, 32'h1100, 32'h12345778);
    expect_rd("R9 load data", 2'd3, 32'h1100, 32'h00001D06);
    expect_rd("R9 load aux", 2'd3, 32'h0080_1100, 32'h00000003);
  endtask

  task automatic t_assoc;
    pte_hi = 32'h0000_0042;
    wr(2'd3, 32'h0A00, 32'h0000_0010);
    wr(2'd2, 32'h0A00, 32'h1000_0042);
    wr(2'd3, 32'h0B00, 32'h0000_0102);
    wr(2'd2, 32'h0B00, 32'h1000_0199);
    wr(2'd2, 32'h0C00, 32'h1000_0C55);
    wr(2'd1, 32'h0080, 32'h0000_0010);
    wr(2'd0, 32'h0080, 32'h1000_0042);
    wr(2'd2, 32'h0080, 32'h1000_0F00);
    chk("R8 single match no flag", {31'd0, multi_hit}, 32'h0);
    expect_rd("R6 4K invalid entry matched", 2'd2, 32'h0A00, 32'h1000_0342);
    expect_rd("R6 1K exact mismatch", 2'd2, 32'h0B00, 32'h1000_0199);
    expect_rd("R6 foreign ID untouched", 2'd2, 32'h0C00, 32'h1000_0C55);
    expect_rd("R6 itlb valid set", 2'd0, 32'h0080, 32'h1000_0142);
    wr(2'd2, 32'h0080, 32'h1000_0000);
    chk("R8 multi flag", {31'd0, multi_hit}, 32'h1);
    @(negedge clk);
    chk("R8 flag one cycle", {31'd0, multi_hit}, 32'h0);
    expect_rd("R6 multi entry 10", 2'd2, 32'h0A00, 32'h1000_0042);
    expect_rd("R6 share entry 11", 2'd2, 32'h0B00, 32'h1000_0099);
    expect_rd("R6 itlb cleared", 2'd0, 32'h0080, 32'h1000_0042);
  endtask

  task automatic t_sizes;
    pte_hi = 32'h0000_0042;
    wr(2'd3, 32'h1400, 32'h0000_0080);
    wr(2'd2, 32'h1400, 32'h2000_0042);
    wr(2'd3, 32'h1500, 32'h0000_0090);
    wr(2'd2, 32'h1500, 32'h3000_0042);
    wr(2'd3, 32'h1600, 32'h0000_0080);
    wr(2'd2, 32'h1600, 32'h4000_0042);
    wr(2'd2, 32'h0080, 32'h2000_FD00);
    wr(2'd2, 32'h0080, 32'h300F_FD00);
    wr(2'd2, 32'h0080, 32'h4001_0100);
    expect_rd("R7 64K ignores low bits", 2'd2, 32'h1400, 32'h2000_0142);
    expect_rd("R7 1M ignores low bits", 2'd2, 32'h1500, 32'h3000_0142);
    expect_rd("R7 64K outside field", 2'd2, 32'h1600, 32'h4000_0042);
  endtask

  task automatic t_inval;
    @(negedge clk); ctrl_we = 1'b1; ctrl_wdata = 32'hFFFFFFFB;
    @(negedge clk); ctrl_we = 1'b0;
    expect_rd("R10 no clear without bit", 2'd2, 32'h1100, 32'h12345778);
    @(negedge clk); ctrl_we = 1'b1; ctrl_wdata = 32'h4;
    @(negedge clk); ctrl_we = 1'b0;
    expect_rd("R10 utlb cleared", 2'd2, 32'h1100, 32'h12345678);
    expect_rd("R10 itlb cleared", 2'd0, 32'h0100, 32'hFFFFFCFF);
    pte_hi = 32'h12345678; pte_lo = 32'hE0001D06; ld_idx = 6'd30;
    @(negedge clk); ld_tlb = 1'b1; ctrl_we = 1'b1;
    @(negedge clk); ld_tlb = 1'b0; ctrl_we = 1'b0;
    expect_rd("R10 clear wins addr", 2'd2, 32'h1E00, 32'h12345678);
    expect_rd("R10 clear wins data", 2'd3, 32'h1E00, 32'h00001C06);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_utlb_addr();
    t_utlb_data();
    t_itlb();
    t_load();
    t_assoc();
    t_sizes();
    t_inval();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule